// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer

This block is a 32-bit down-counting timer driven by a fixed-ratio tick. A free-running prescaler divides the system clock by a parameterised ratio. The default ratio is 20, which turns a 20 MHz clock into a 1 MHz tick. On each qualified tick the count register steps down by one. A 2-bit mode field selects what happens at zero: the counter can be halted, run freely, reload automatically, or produce a pulse-width output.

Counting needs three things at once: the mode must not be halt, software must set a run bit, and a hardware enable pin must sit at a level that software picks. Software sees and sets the timer through a small word-addressed register port with single-cycle writes and a combinational read. When the count steps down to zero and the interrupt enable is set, a sticky interrupt flag is raised. Any write to the control word clears that flag.

Top module: `mmt_timer`

## Requirements
- R1: After reset the control, reload and current words read zero, and `irq` and `pwm_out` are low.
- R2: The register port decodes word 0 as control, word 1 as reload and word 2 as current. Words 3 to 7 read zero and ignore writes. In the control word, bit 22 is interrupt enable, bit 21 is count-through-zero, bits 20:19 are the mode (0 halt, 1 free, 2 reload, 3 PWM), bit 18 is the run request and bit 17 is the enable polarity. Bit 16 is read-only status. All other control bits read zero.
- R3: A tick occurs once every 20 clocks. Across any 100 consecutive clock edges of an enabled counter with a nonzero count, the count changes exactly 5 times, by one each time.
- R4: The counter advances only when all of these hold: the mode is not halt, the run bit is 1, and `hw_en` equals the polarity bit. Control bit 16 reads 1 exactly when these conditions hold.
- R5: In halt mode the count holds its value whatever the run bit and `hw_en` are.
- R6: In free mode with count-through-zero clear, the count stops at zero. With count-through-zero set, a qualified tick at zero loads 0xFFFFFFFF.
- R7: In reload mode, a qualified tick at zero loads the reload value.
- R8: `pwm_out` is high exactly when the mode is PWM and the current count is less than the reload value shifted right by one. In PWM mode, a qualified tick at zero loads the reload value.
- R9: A qualified tick that moves the count from 1 to 0 while interrupt enable is set raises `irq`. `irq` stays high until a write to the control word. A write of the control word in the same cycle as such a tick leaves the flag set.
- R10: A write to the current word takes effect on that clock edge and overrides any decrement due at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Hardware count enable, polarity set by control bit 17 |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Word index of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the word at `reg_addr` |
| irq | output | 1 | Sticky zero-reached interrupt flag |
| pwm_out | output | 1 | Pulse-width output in PWM mode |

## Verification
The hardest situations to reach from the ports are the exact tick on which the count sits at zero or one. This is where wrap, reload, interrupt set and a competing software write all meet, and it happens on only one clock in twenty. The stimulus keeps loading small values into the current and reload words, so the count reaches zero every few dozen ticks. A 32-bit wrap therefore comes within reach without waiting for billions of ticks. A cycle-accurate reference model in the bench tracks the prescaler phase from reset. Each random write, enable toggle and mode change is therefore checked against the exact cycle it lands in, and directed cases cover the phase-independent behaviour.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

    typedef enum logic [1:0] {
        MODE_HALT   = 2'd0,
        MODE_FREE   = 2'd1,
        MODE_RELOAD = 2'd2,
        MODE_PWM    = 2'd3
    } mode_e;

    // Packed so that the MSB lands on control bit 22 and the LSB on bit 17.
    typedef struct packed {
        logic  irq_en;
        logic  wrap_en;
        mode_e mode;
        logic  run;
        logic  en_pol;
    } ctl_t;

    localparam int CTL_MSB    = 22;
    localparam int CTL_LSB    = 17;
    localparam int STAT_BIT   = 16;
    localparam int BUS_W      = 32;

    localparam int WORD_CTL    = 0;
    localparam int WORD_RELOAD = 1;
    localparam int WORD_COUNT  = 2;

endpackage

// File: rtl/mmt_prescaler.sv
module mmt_prescaler #(
    parameter int DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;

    always_comb begin
        pre_d  = pre_q;
        tick_o = (pre_q.cnt == PW'(DIV - 1));
        if (tick_o) begin
            pre_d.cnt = '0;
        end else begin
            pre_d.cnt = pre_q.cnt + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    generate
        if (DIV > 1) begin : g_gap_chk
            // R3: two ticks never fall on adjacent cycles
            a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

    // R3: phase counter never leaves its range
    a_r3_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q.cnt <= PW'(DIV - 1));

endmodule

// File: rtl/mmt_counter.sv
module mmt_counter
    import mmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             count_en_i,
    input  mode_e            mode_i,
    input  logic             wrap_en_i,
    input  logic             irq_en_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             wr_cnt_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             clr_irq_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o,
    output logic             pwm_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       step;
    logic       hit;

    always_comb begin
        st_d = st_q;
        step = tick_i && count_en_i;
        hit  = step && (st_q.cnt == CNT_W'(1));

        if (wr_cnt_i) begin
            st_d.cnt = wr_data_i;
        end else if (step) begin
            if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end else begin
                unique case (mode_i)
                    MODE_FREE:   st_d.cnt = wrap_en_i ? '1 : '0;
                    MODE_RELOAD: st_d.cnt = reload_i;
                    MODE_PWM:    st_d.cnt = reload_i;
                    default:     st_d.cnt = st_q.cnt;
                endcase
            end
        end

        if (hit && irq_en_i) begin
            st_d.irq = 1'b1;
        end else if (clr_irq_i) begin
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign irq_o = st_q.irq;
    assign pwm_o = (mode_i == MODE_PWM) && (st_q.cnt < (reload_i >> 1));

    // R5: halt mode never moves the count on its own
    a_r5_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_HALT && !wr_cnt_i) |=> $stable(st_q.cnt));

    // R4: unqualified cycles leave the count alone
    a_r4_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en_i && !wr_cnt_i) |=> $stable(st_q.cnt));

    // R6: free mode without wrap stays parked at zero
    a_r6_park_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_FREE && !wrap_en_i && st_q.cnt == '0 && !wr_cnt_i)
        |=> st_q.cnt == '0);

    // R7: reload mode restarts from the reload word
    a_r7_reload_load: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_RELOAD && step && st_q.cnt == '0 && !wr_cnt_i)
        |=> st_q.cnt == $past(reload_i));

    // R9: flag is sticky until a control write
    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !clr_irq_i) |=> st_q.irq);

    // R9: a qualifying zero arrival always raises the flag
    a_r9_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && irq_en_i) |=> st_q.irq);

    // R10: software write lands on the next edge
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_i |=> st_q.cnt == $past(wr_data_i));

endmodule

// File: rtl/mmt_timer.sv
module mmt_timer
    import mmt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DIV    = 20,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              pwm_out
);
    typedef struct packed {
        ctl_t             ctl;
        logic [CNT_W-1:0] rel;
    } regs_t;

    regs_t            rg_d, rg_q;
    logic             wr_ctl;
    logic             wr_rel;
    logic             wr_cnt;
    logic             count_en;
    logic             tick;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        rg_d   = rg_q;
        wr_ctl = reg_wr && (reg_addr == ADDR_W'(WORD_CTL));
        wr_rel = reg_wr && (reg_addr == ADDR_W'(WORD_RELOAD));
        wr_cnt = reg_wr && (reg_addr == ADDR_W'(WORD_COUNT));
        if (wr_ctl) begin
            rg_d.ctl = ctl_t'(reg_wdata[CTL_MSB:CTL_LSB]);
        end
        if (wr_rel) begin
            rg_d.rel = reg_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign count_en = (rg_q.ctl.mode != MODE_HALT) && rg_q.ctl.run &&
                      (hw_en == rg_q.ctl.en_pol);

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(WORD_CTL)) begin
            reg_rdata[CTL_MSB:CTL_LSB] = rg_q.ctl;
            reg_rdata[STAT_BIT]        = count_en;
        end else if (reg_addr == ADDR_W'(WORD_RELOAD)) begin
            reg_rdata[CNT_W-1:0] = rg_q.rel;
        end else if (reg_addr == ADDR_W'(WORD_COUNT)) begin
            reg_rdata[CNT_W-1:0] = cnt;
        end
    end

    mmt_prescaler #(
        .DIV (DIV)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    mmt_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .count_en_i (count_en),
        .mode_i     (rg_q.ctl.mode),
        .wrap_en_i  (rg_q.ctl.wrap_en),
        .irq_en_i   (rg_q.ctl.irq_en),
        .reload_i   (rg_q.rel),
        .wr_cnt_i   (wr_cnt),
        .wr_data_i  (reg_wdata[CNT_W-1:0]),
        .clr_irq_i  (wr_ctl),
        .cnt_o      (cnt),
        .irq_o      (irq),
        .pwm_o      (pwm_out)
    );

    // R2: reload word changes only through its own address
    a_r2_reload_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADDR_W'(WORD_RELOAD)) |=> $stable(rg_q.rel));

    // R2: control word changes only through its own address
    a_r2_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADDR_W'(WORD_CTL)) |=> $stable(rg_q.ctl));

endmodule

// File: tb/mmt_timer_bench.sv
`timescale 1ns/1ps
module mmt_timer_bench;
    localparam int DIV = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        pwm_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    mmt_timer u_mmt_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_en     (hw_en),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .pwm_out   (pwm_out)
    );

    // ---------------- reference model from the requirements ----------------
    logic [31:0] m_cur, m_rel;
    logic        m_ie, m_thru, m_run, m_pol, m_flag;
    logic [1:0]  m_mode;
    int          m_ph;
    logic        m_tk;
    logic        m_en;

    assign m_tk = (m_ph == DIV - 1);
    assign m_en = (m_mode != 2'd0) && m_run && (hw_en == m_pol);

    function automatic logic [31:0] m_next_zero();
        if (m_mode == 2'd1) return m_thru ? 32'hFFFF_FFFF : 32'h0;
        if (m_mode == 2'd0) return 32'h0;
        return m_rel;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cur <= '0; m_rel <= '0; m_ie <= 0; m_thru <= 0; m_run <= 0;
            m_pol <= 0; m_mode <= '0; m_flag <= 0; m_ph <= 0;
        end else begin
            m_ph <= m_tk ? 0 : m_ph + 1;
            if (reg_wr && reg_addr == 3'd2) m_cur <= reg_wdata;
            else if (m_tk && m_en) m_cur <= (m_cur != 0) ? m_cur - 1 : m_next_zero();
            if (m_tk && m_en && m_cur == 32'd1 && m_ie) m_flag <= 1'b1;
            else if (reg_wr && reg_addr == 3'd0) m_flag <= 1'b0;
            if (reg_wr && reg_addr == 3'd0) begin
                m_ie   <= reg_wdata[22];
                m_thru <= reg_wdata[21];
                m_mode <= reg_wdata[20:19];
                m_run  <= reg_wdata[18];
                m_pol  <= reg_wdata[17];
            end
            if (reg_wr && reg_addr == 3'd1) m_rel <= reg_wdata;
        end
    end

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {9'b0, m_ie, m_thru, m_mode, m_run, m_pol, m_en, 16'b0};
            3'd1: return m_rel;
            3'd2: return m_cur;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic m_pwm();
        return (m_mode == 2'd3) && (m_cur < (m_rel >> 1));
    endfunction

    function automatic logic [31:0] ctl_word(input logic ie, thru, input logic [1:0] md,
                                             input logic run, pol);
        return {9'b0, ie, thru, md, run, pol, 17'b0};
    endfunction

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_cond(input string tag, input bit ok, input logic [31:0] act,
                            input string exp_txt);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %s", tag, act, exp_txt);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = $urandom;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_model(input string tag, input logic [2:0] a);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, m_read(a));
        chk({tag, " irq"}, {31'b0, irq}, {31'b0, m_flag});
        chk({tag, " pwm"}, {31'b0, pwm_out}, {31'b0, m_pwm()});
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] v, prev;
        int          changes;
        bit          step_ok;
        int unsigned seed;
        seed = 32'd20240611;
        v = $urandom(seed);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v); chk("R1 ctl after reset", v, 32'h0);
        rd(3'd1, v); chk("R1 reload after reset", v, 32'h0);
        rd(3'd2, v); chk("R1 current after reset", v, 32'h0);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        chk("R1 pwm after reset", {31'b0, pwm_out}, 32'h0);

        // R5 halt holds the count even with run set
        wr(3'd2, 32'd7);
        hw_en = 1'b0;
        wr(3'd0, ctl_word(1'b1, 1'b0, 2'd0, 1'b1, 1'b0));
        idle(200);
        rd(3'd2, v); chk("R5 halt holds count", v, 32'd7);
        rd(3'd0, v); chk("R4 status low in halt", {31'b0, v[16]}, 32'h0);

        // R6 free mode stops at zero, R9 irq raised
        hw_en = 1'b1;
        wr(3'd2, 32'd3);
        wr(3'd0, ctl_word(1'b1, 1'b0, 2'd1, 1'b1, 1'b1));
        idle(200);
        rd(3'd2, v); chk("R6 free stops at zero", v, 32'd0);
        chk("R9 irq raised at zero", {31'b0, irq}, 32'h1);
        rd(3'd0, v); chk("R4 status high when qualified", {31'b0, v[16]}, 32'h1);
        chk("R2 control readback", v & 32'hFFFE_FFFF, ctl_word(1'b1, 1'b0, 2'd1, 1'b1, 1'b1));

        // R9 control write clears the flag
        wr(3'd0, ctl_word(1'b1, 1'b0, 2'd1, 1'b1, 1'b1));
        chk("R9 control write clears irq", {31'b0, irq}, 32'h0);

        // R6 count through zero wraps
        wr(3'd0, ctl_word(1'b0, 1'b1, 2'd1, 1'b1, 1'b1));
        idle(100);
        rd(3'd2, v);
        chk_cond("R6 wrap to all ones", v[31:8] == 24'hFF_FFFF, v, "0xFFFFFFxx");
        chk("R9 no irq when disabled", {31'b0, irq}, 32'h0);

        // R3 tick spacing over 100 edges
        wr(3'd2, 32'd1000);
        rd(3'd2, prev);
        changes = 0; step_ok = 1'b1;
        for (int i = 0; i < 100; i++) begin
            rd(3'd2, v);
            if (v != prev) begin
                changes++;
                if (prev - v != 32'd1) step_ok = 1'b0;
            end
            prev = v;
        end
        chk("R3 ticks per 100 clocks", changes, 32'd5);
        chk("R3 step size one", {31'b0, step_ok}, 32'h1);

        // R4 polarity qualification
        hw_en = 1'b0;
        wr(3'd2, 32'd50);
        idle(200);
        rd(3'd2, v); chk("R4 wrong polarity holds", v, 32'd50);
        wr(3'd0, ctl_word(1'b0, 1'b0, 2'd1, 1'b1, 1'b0));
        idle(200);
        rd(3'd2, v);
        chk_cond("R4 active-low enable counts", v < 32'd50 && v > 32'd35, v, "36..49");
        wr(3'd0, ctl_word(1'b0, 1'b0, 2'd1, 1'b0, 1'b0));
        rd(3'd2, prev); idle(200); rd(3'd2, v);
        chk("R4 run bit clear holds", v, prev);

        // R2 reserved words
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, v); chk("R2 reserved reads zero", v, 32'h0);
        rd(3'd2, v); chk("R2 reserved write ignored (current)", v, prev);
        rd(3'd0, v); chk("R2 reserved write ignored (ctl)", v,
                         ctl_word(1'b0, 1'b0, 2'd1, 1'b0, 1'b0));

        // R7 reload mode
        hw_en = 1'b1;
        wr(3'd1, 32'd4);
        wr(3'd2, 32'd1);
        wr(3'd0, ctl_word(1'b1, 1'b0, 2'd2, 1'b1, 1'b1));
        idle(400);
        rd(3'd2, v); chk_cond("R7 reload keeps count in range", v <= 32'd4, v, "0..4");
        chk("R9 irq in reload mode", {31'b0, irq}, 32'h1);
        rd_model("R7 reload model", 3'd2);

        // R10 write wins while counting
        wr(3'd2, 32'h1234_5678);
        rd(3'd2, v);
        chk_cond("R10 write lands", v == 32'h1234_5678 || v == 32'h1234_5677, v, "0x12345678/77");
        chk("R10 write model", v, m_cur);

        // R8 PWM
        wr(3'd1, 32'd20);
        wr(3'd2, 32'd20);
        wr(3'd0, ctl_word(1'b0, 1'b0, 2'd3, 1'b1, 1'b1));
        chk("R8 pwm low at top of count", {31'b0, pwm_out}, 32'h0);
        for (int i = 0; i < 500; i++) begin
            @(negedge clk); #1;
            chk("R8 pwm vs model", {31'b0, pwm_out}, {31'b0, m_pwm()});
        end

        // random mixed stimulus against the model
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 6);
            case (op)
                0: begin
                    logic [31:0] w;
                    w = $urandom;
                    w[18] = ($urandom % 4) != 0;
                    wr(3'd0, w);
                end
                1: wr(3'd1, $urandom % 48);
                2: wr(3'd2, ($urandom % 8 == 0) ? $urandom : ($urandom % 48));
                3: begin @(negedge clk); hw_en = ~hw_en; end
                4: wr(3'(3 + $urandom % 5), $urandom);
                default: idle(1);
            endcase
            idle(int'($urandom % 60));
            begin
                logic [2:0] a;
                a = 3'($urandom % 8);
                case (a)
                    3'd0: rd_model("R4 random ctl/status", a);
                    3'd1: rd_model("R2 random reload", a);
                    3'd2: rd_model(m_mode == 2'd1 ? "R6 random count" :
                                   m_mode == 2'd0 ? "R5 random count" : "R7 random count", a);
                    default: rd_model("R2 random reserved", a);
                endcase
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule